// File: doc/BRIEF.md
# Release-Gated Function Unit Grant Picker

This block arbitrates the read and write ports of a scoreboard among a set of function units. Each unit is marked busy when it is issued. Each unit also reports two hazard-clear signals, one for reads and one for writes. These signals stay high even when the unit is idle. If the raw hazard-clear signals went straight into a fixed-priority picker, the lowest-indexed unit would win every cycle, whether or not it had any work. To prevent this, each unit keeps a read-release flag and a write-release flag. The unit shows a request to the picker only while the matching flag is set.

The read-release flag is set at issue when the unit has operands to read. It drops when the unit's read grant is seen. Completing the read phase sets the write-release flag. A unit with nothing to read sets the write-release flag directly at issue. Grants are registered. This breaks the loop from grant back to request, and a unit's own request is masked during the cycle its grant is high. A unit stays busy until the cycle after its final grant. A unit that needs neither port clears one cycle after issue.

Top module: `fu_release_picker`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with no issue, go_rd_o, go_wr_o and busy_o are all zero.
- R2: A high issue_i bit for a unit that is not busy sets that unit's busy_o bit after the sampling edge. Issue on a unit that is already busy is ignored: its need flags are not reloaded.
- R3: A unit issued with need_rd_i low never receives go_rd_o. A unit issued with need_wr_i low never receives go_wr_o.
- R4: A unit whose busy_o is low never receives go_rd_o or go_wr_o, even with its hazard-clear inputs high.
- R5: When several units request the same port, the lowest index wins. A losing unit keeps its request and is granted in a later cycle.
- R6: Each of go_rd_o and go_wr_o has at most one bit set in any cycle.
- R7: A read grant goes high on the edge after the first cycle in which the unit's read-release flag and rd_free_i are both high. It lasts exactly one cycle. A low rd_free_i holds the grant off.
- R8: The write-release flag is set by a seen read grant when the unit needs a write, or at issue when the unit needs a write and no read. Its grant follows the same one-cycle timing as R7, gated by wr_free_i.
- R9: busy_o clears on the edge that samples the unit's final grant. That is go_wr_o, or go_rd_o for a unit with no write. A unit issued with neither need clears one cycle after issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | NUM_FU | Per-unit issue strobe |
| need_rd_i | input | NUM_FU | Unit has source operands to read (sampled at issue) |
| need_wr_i | input | NUM_FU | Unit has a result to write (sampled at issue) |
| rd_free_i | input | NUM_FU | Per-unit no-read-hazard signal, may be high while idle |
| wr_free_i | input | NUM_FU | Per-unit no-write-hazard signal, may be high while idle |
| go_rd_o | output | NUM_FU | Registered read-port grant, one-hot or zero |
| go_wr_o | output | NUM_FU | Registered write-port grant, one-hot or zero |
| busy_o | output | NUM_FU | Per-unit busy flag |

## Verification
A cycle table drives four patterns, each with the hazard-clear inputs held high on idle units:
- a lone unit through read and then write;
- two units issued together, to show index order and that the loser's request is kept;
- a read-only pair in which one unit's rd_free_i is held low while a higher index proceeds;
- units with only a write, or with no port at all.

Together these separate release gating from priority, hazard blocking from arbitration loss, and the three ways busy can clear. A repeated issue on a busy unit with zero need flags shows whether the flags are reloaded. Directed steps then check reset both mid-flight and at start.

// File: rtl/fu_pick_pkg.sv
package fu_pick_pkg;
  typedef struct packed {
    logic busy;
    logic rd_rel;
    logic wr_rel;
    logic wr_need;
  } fu_state_t;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  logic [W-1:0] lower_any;

  assign lower_any[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign lower_any[i] = lower_any[i-1] | req_i[i-1];
  end

  assign gnt_o = req_i & ~lower_any;

  always_comb begin
    assert_pick_subset_R5: assert ((gnt_o & ~req_i) == '0);
  end
endmodule

// File: rtl/fu_release_cell.sv
module fu_release_cell
  import fu_pick_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic need_rd_i,
  input  logic need_wr_i,
  input  logic rd_free_i,
  input  logic wr_free_i,
  input  logic go_rd_i,
  input  logic go_wr_i,
  output logic busy_o,
  output logic rd_req_o,
  output logic wr_req_o
);
  fu_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (!st_q.busy) begin
      if (issue_i) begin
        st_q.busy    <= 1'b1;
        st_q.rd_rel  <= need_rd_i;
        st_q.wr_rel  <= need_wr_i & ~need_rd_i;
        st_q.wr_need <= need_wr_i;
      end
    end else if (go_wr_i) begin
      st_q.wr_rel <= 1'b0;
      st_q.busy   <= 1'b0;
    end else if (go_rd_i) begin
      st_q.rd_rel <= 1'b0;
      if (st_q.wr_need) st_q.wr_rel <= 1'b1;
      else              st_q.busy   <= 1'b0;
    end else if (!st_q.rd_rel && !st_q.wr_rel) begin
      st_q.busy <= 1'b0;  // nothing to do
    end
  end

  // own grant masks own request: breaks the grant->request loop
  assign rd_req_o = st_q.rd_rel & rd_free_i & ~go_rd_i;
  assign wr_req_o = st_q.wr_rel & wr_free_i & ~go_wr_i;
  assign busy_o   = st_q.busy;

  assert_issue_sets_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !busy_o |=> busy_o);
  assert_no_grant_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_rd_i || go_wr_i) |-> busy_o);
  assert_rd_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_rd_i |=> !go_rd_i);
  assert_wr_frees_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wr_i |=> !busy_o);
  assert_wr_after_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wr_i |-> !st_q.rd_rel);
endmodule

// File: rtl/fu_release_picker.sv
module fu_release_picker #(
  parameter int NUM_FU = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_FU-1:0] issue_i,
  input  logic [NUM_FU-1:0] need_rd_i,
  input  logic [NUM_FU-1:0] need_wr_i,
  input  logic [NUM_FU-1:0] rd_free_i,
  input  logic [NUM_FU-1:0] wr_free_i,
  output logic [NUM_FU-1:0] go_rd_o,
  output logic [NUM_FU-1:0] go_wr_o,
  output logic [NUM_FU-1:0] busy_o
);
  logic [NUM_FU-1:0] rd_req, wr_req;
  logic [NUM_FU-1:0] rd_gnt, wr_gnt;
  logic [NUM_FU-1:0] go_rd_q, go_wr_q;

  for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
    fu_release_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (issue_i[i]),
      .need_rd_i (need_rd_i[i]),
      .need_wr_i (need_wr_i[i]),
      .rd_free_i (rd_free_i[i]),
      .wr_free_i (wr_free_i[i]),
      .go_rd_i   (go_rd_q[i]),
      .go_wr_i   (go_wr_q[i]),
      .busy_o    (busy_o[i]),
      .rd_req_o  (rd_req[i]),
      .wr_req_o  (wr_req[i])
    );
  end

  prio_pick #(.W(NUM_FU)) u_rd_pick (.req_i(rd_req), .gnt_o(rd_gnt));
  prio_pick #(.W(NUM_FU)) u_wr_pick (.req_i(wr_req), .gnt_o(wr_gnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_rd_q <= '0;
      go_wr_q <= '0;
    end else begin
      go_rd_q <= rd_gnt;
      go_wr_q <= wr_gnt;
    end
  end

  assign go_rd_o = go_rd_q;
  assign go_wr_o = go_wr_q;

  assert_rd_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_rd_o));
  assert_wr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_wr_o));

  for (genvar i = 0; i < NUM_FU; i++) begin : g_chk
    localparam logic [NUM_FU-1:0] LOWER = NUM_FU'((1 << i) - 1);
    assert_rd_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_rd_o[i] |-> ($past(rd_req) & LOWER) == '0);
    assert_wr_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_wr_o[i] |-> ($past(wr_req) & LOWER) == '0);
    assert_rd_from_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_rd_o[i] |-> $past(rd_req[i]));
  end
endmodule

// File: tb/fu_release_picker_tb.sv
module fu_release_picker_tb;
  localparam int N = 4;
  localparam int ROWS = 23;
  // nibbles: issue, need_rd, need_wr, rd_free, wr_free, exp go_rd, exp go_wr, exp busy
  localparam logic [31:0] TBL [ROWS] = '{
    32'h111FF001, 32'h100FF101, 32'h000FF001, 32'h000FF011, 32'h000FF000,
    32'h666FF006, 32'h000FF206, 32'h000FF406, 32'h000FF026, 32'h000FF044,
    32'h000FF000,
    32'h9908F009, 32'h0008F809, 32'h0008F001, 32'h000FF101, 32'h000FF000,
    32'h400FF004, 32'h000FF000,
    32'h202F0002, 32'h000F0002, 32'h000FF022, 32'h000FF000,
    32'h000FF000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] issue = '0, nrd = '0, nwr = '0, rdf = '1, wrf = '1;
  logic [N-1:0] go_rd, go_wr, busy;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fu_release_picker #(.NUM_FU(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .need_rd_i(nrd), .need_wr_i(nwr),
    .rd_free_i(rdf), .wr_free_i(wrf), .go_rd_o(go_rd), .go_wr_o(go_wr), .busy_o(busy)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 go_rd in reset", go_rd, '0);
    check("R1 go_wr in reset", go_wr, '0);
    check("R1 busy in reset", busy, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, '0);
    check("R4 idle free units no rd grant", go_rd, '0);
    check("R4 idle free units no wr grant", go_wr, '0);

    // table: R2 R3 R5 R7 R8 R9 scenarios
    for (int k = 0; k < ROWS; k++) begin
      {issue, nrd, nwr, rdf, wrf} = TBL[k][31:12];
      @(negedge clk);
      check($sformatf("R3 R5 R7 go_rd row %0d", k), go_rd, TBL[k][11:8]);
      check($sformatf("R3 R8 go_wr row %0d", k), go_wr, TBL[k][7:4]);
      check($sformatf("R2 R9 busy row %0d", k), busy, TBL[k][3:0]);
      check($sformatf("R4 grant to idle row %0d", k), (go_rd | go_wr) & ~busy, '0);
      check($sformatf("R6 onehot row %0d", k),
            {2'b00, $onehot0(go_rd), $onehot0(go_wr)}, 4'b0011);
    end

    // R1 asynchronous reset mid-flight
    issue = 4'h1; nrd = 4'h1; nwr = 4'h1;
    @(negedge clk);
    issue = '0;
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async go_rd", go_rd, '0);
    check("R1 async busy", busy, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 post reset go_rd", go_rd, '0);
    check("R1 post reset busy", busy, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule